// File: doc/BRIEF.md
# Lane Protocol Switch Sequencer

This block moves one lane of an eight-lane serial transceiver between a 1G mode (SGMII or 1000BASE-X) and a 10G mode (10GBASE-R). A single request names the lane, the target mode, the lane's present protocol and whether the lane is powered up. The block then works through a fixed list of register operations on a simple register port. Most of these are read-modify-write pairs. A few are plain writes. The rest are status polls.

For a powered lane, the block first halts the transmit and receive halves and waits for both halts to finish. It then does four things: it clears the old protocol's field in the shared protocol registers, programs the new protocol, selects a PLL and a clock divider, and loads the per-mode equalisation words. Last, it resets the lane back to its running state and waits until both halves report that the reset is complete.

The PLL is chosen from a per-PLL summary: a disable flag and a 2-bit capability class. A request the block cannot serve is refused. It gets an error pulse and no register traffic.

Top module: `lane_mode_seq`

## Requirements
- R1: A request is refused when the present protocol code is neither 1 (1G) nor 2 (10G), or when no PLL is eligible. A refused request raises `err` for one cycle, leaves `busy` low and produces no register read or write.
- R2: `busy` rises the cycle after an accepted request. It falls in the same cycle as a one-cycle `done` pulse at the end of the list. A request presented while `busy` is high has no effect, and no register access occurs while `busy` is low.
- R3: Each lane has a 4-bit field in both shared protocol registers (1G register at 0x10A0, 10G register at 0x10B0). The field for lane n sits at bit 4*(7-n). Before anything else is programmed, the field for the lane's present protocol is written to 0.
- R4: The new mode's field is then set. A 1G mode writes value 1 into the 1G register. A 10G mode writes value 9 into the 10G register.
- R5: Bits 7:0 of the lane control word (0x800 + 0x100*n) become 0x08 for 1G and 0x52 for 10G.
- R6: The PLL used is the lowest-indexed one that is not disabled and whose class matches the mode (class 1 serves 1G, class 2 serves 10G; classes 0 and 3 serve nothing). Bit 28 of both the TX word (+0x24) and the RX word (+0x44) takes the PLL index.
- R7: Bits 26:24 of the TX and RX words take the divider: 2 (quarter rate) for 1G, 0 (full rate) for 10G.
- R8: Bit 11 of the lane's PCS control word (0x1804 + 0x10*n) is 1 for 1G and 0 for 10G. It is written after the PLL and divider fields.
- R9: Six equalisation words are written whole with per-mode constants. The lane offsets are +0x30, +0x48, +0x50, +0x54, +0x58 and +0x74.
- R10: Each field update is one read followed by one write in which only the field's bits change. A read strobe lasts one cycle and never coincides with a write strobe.
- R11: For a powered lane, halt bit 27 is set in the TX reset word (+0x20) and the RX reset word (+0x40), and both are polled until bit 27 reads 0. At the end, bit 31 is set in both and both are polled until bit 30 reads 1. An unpowered lane's reset words are not accessed.
- R12: Writes occur in this order: halts, clear of the old field, new field, control byte, TX then RX PLL bit, TX then RX divider, PCS bit, equalisation words, reset requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Mode-change request strobe |
| req_lane | input | 3 | Lane index |
| req_mode_10g | input | 1 | Target mode: 1 = 10G, 0 = 1G |
| req_cur_proto | input | 2 | Present protocol: 1 = 1G, 2 = 10G, others unknown |
| req_powered | input | 1 | Lane is presently powered up |
| pll_disabled | input | 2 | Per-PLL disable flag |
| pll_class | input | 4 | Per-PLL 2-bit capability class, PLL i at bits 2i+1:2i |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at sequence end |
| err | output | 1 | One-cycle pulse for a refused request |
| reg_rd_en | output | 1 | Register read strobe |
| reg_wr_en | output | 1 | Register write strobe |
| reg_addr | output | 16 | Register byte address |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, valid the cycle after the read strobe |

## Verification
The bench builds the block with its defaults: eight lanes and two PLLs. With these values every nibble position of the mirrored field placement can be reached, including the top nibble for lane 0 and the bottom nibble for lane 7. Two PLLs are also enough to exercise the priority choice between them, including the case where the first PLL is disabled or of the wrong class. A register model that answers polls only after a few reads exercises the halt and reset wait loops.

// File: rtl/lms_pkg.sv
// Shared types and address constants for the lane protocol switch sequencer.
// Assumes a 16-bit byte-addressed register space with 32-bit words.
package lms_pkg;
    localparam int ADDR_W      = 16;
    localparam int DATA_W      = 32;
    localparam int NIB_W       = 4;
    localparam int LANE_BASE   = 'h800;
    localparam int LANE_STRIDE = 'h100;
    localparam int SHR_1G      = 'h10A0;
    localparam int SHR_10G     = 'h10B0;
    localparam int PCS_BASE    = 'h1804;
    localparam int PCS_STRIDE  = 'h10;
    localparam int OFF_CTL     = 'h00;
    localparam int OFF_TRST    = 'h20;
    localparam int OFF_TCTL    = 'h24;
    localparam int OFF_RRST    = 'h40;
    localparam int OFF_RCTL    = 'h44;
    localparam int BIT_HALT    = 27;
    localparam int BIT_RDONE   = 30;
    localparam int BIT_RREQ    = 31;
    localparam int BIT_PLL     = 28;
    localparam int RATE_LSB    = 24;
    localparam int BIT_PCS     = 11;
    localparam int N_STEPS     = 22;
    localparam int STEP_W      = $clog2(N_STEPS + 1);

    localparam logic [1:0] PROTO_1G  = 2'd1;
    localparam logic [1:0] PROTO_10G = 2'd2;
    localparam logic [1:0] CLS_1G    = 2'd1;
    localparam logic [1:0] CLS_10G   = 2'd2;

    typedef enum logic [1:0] {K_SKIP, K_WRITE, K_RMW, K_POLL} step_kind_e;
    typedef enum logic [1:0] {S_IDLE, S_RUN, S_RDWAIT, S_RDCAP} seq_state_e;

    typedef struct packed {
        step_kind_e          kind;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   mask;
        logic [DATA_W-1:0]   val;
    } step_t;

    // Lane-relative offset of equalisation word k
    function automatic int eq_off(input int k);
        case (k)
            0: return 'h30;
            1: return 'h48;
            2: return 'h50;
            3: return 'h54;
            4: return 'h58;
            default: return 'h74;
        endcase
    endfunction

    // Equalisation constant k for the chosen mode
    function automatic logic [DATA_W-1:0] eq_word(input int k, input logic m10);
        case (k)
            0: return m10 ? 32'h1080_8307 : 32'h0080_8006;
            1: return m10 ? 32'h1000_0000 : 32'h0431_0000;
            2: return m10 ? 32'h0000_0000 : 32'h9F80_0000;
            3: return 32'h001F_0000;
            4: return m10 ? 32'h8100_0020 : 32'h0000_0000;
            default: return m10 ? 32'h0000_2000 : 32'h0000_0000;
        endcase
    endfunction
endpackage

// File: rtl/lms_pll_pick.sv
// Picks the lowest-indexed enabled PLL whose class matches the wanted mode.
// Assumes class codes from lms_pkg; purely combinational.
module lms_pll_pick
    import lms_pkg::*;
#(
    parameter int NUM_PLL = 2,
    localparam int PLL_W  = (NUM_PLL > 1) ? $clog2(NUM_PLL) : 1
) (
    input  logic [NUM_PLL-1:0]   dis,
    input  logic [2*NUM_PLL-1:0] cls,
    input  logic                 want_10g,
    output logic                 found,
    output logic [PLL_W-1:0]     idx
);
    logic [NUM_PLL-1:0] ok;

    for (genvar g = 0; g < NUM_PLL; g++) begin : g_ok
        assign ok[g] = !dis[g] && (cls[2*g +: 2] == (want_10g ? CLS_10G : CLS_1G));
    end

    // Priority scan: the lowest index wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_PLL - 1; i >= 0; i--) begin
            if (ok[i]) begin
                found = 1'b1;
                idx   = PLL_W'(i);
            end
        end
    end
endmodule

// File: rtl/lms_step_gen.sv
// Decodes a step index into one register operation for the latched request.
// Assumes lane fields mirror by index in the shared registers; combinational.
module lms_step_gen
    import lms_pkg::*;
#(
    parameter int NUM_LANE = 8,
    parameter int NUM_PLL  = 2,
    localparam int LANE_W  = $clog2(NUM_LANE),
    localparam int PLL_W   = (NUM_PLL > 1) ? $clog2(NUM_PLL) : 1
) (
    input  logic [STEP_W-1:0] step,
    input  logic [LANE_W-1:0] lane,
    input  logic              m10,
    input  logic              old10,
    input  logic [PLL_W-1:0]  pll,
    input  logic              powered,
    output step_t             op
);
    localparam logic [DATA_W-1:0] HALT_M = DATA_W'(1) << BIT_HALT;
    localparam logic [DATA_W-1:0] RREQ_M = DATA_W'(1) << BIT_RREQ;
    localparam logic [DATA_W-1:0] RDON_M = DATA_W'(1) << BIT_RDONE;

    int base;
    int sh;
    int k;

    // Build the operation for the current step
    always_comb begin
        base    = LANE_BASE + int'(lane) * LANE_STRIDE;
        sh      = NIB_W * (NUM_LANE - 1 - int'(lane));
        k       = int'(step) - 12;
        op.kind = K_SKIP;
        op.addr = '0;
        op.mask = '0;
        op.val  = '0;
        case (int'(step))
            0, 1: if (powered) begin
                op.kind = K_RMW;
                op.addr = ADDR_W'(base + ((step == 0) ? OFF_TRST : OFF_RRST));
                op.mask = HALT_M;
                op.val  = HALT_M;
            end
            2, 3: if (powered) begin
                op.kind = K_POLL;
                op.addr = ADDR_W'(base + ((step == 2) ? OFF_TRST : OFF_RRST));
                op.mask = HALT_M;
                op.val  = '0;
            end
            4: begin
                op.kind = K_RMW;
                op.addr = ADDR_W'(old10 ? SHR_10G : SHR_1G);
                op.mask = DATA_W'(4'hF) << sh;
                op.val  = '0;
            end
            5: begin
                op.kind = K_RMW;
                op.addr = ADDR_W'(m10 ? SHR_10G : SHR_1G);
                op.mask = DATA_W'(4'hF) << sh;
                op.val  = DATA_W'(m10 ? 4'h9 : 4'h1) << sh;
            end
            6: begin
                op.kind = K_RMW;
                op.addr = ADDR_W'(base + OFF_CTL);
                op.mask = DATA_W'(8'hFF);
                op.val  = DATA_W'(m10 ? 8'h52 : 8'h08);
            end
            7, 8: begin
                op.kind = K_RMW;
                op.addr = ADDR_W'(base + ((step == 7) ? OFF_TCTL : OFF_RCTL));
                op.mask = DATA_W'(1) << BIT_PLL;
                op.val  = DATA_W'(pll) << BIT_PLL;
            end
            9, 10: begin
                op.kind = K_RMW;
                op.addr = ADDR_W'(base + ((step == 9) ? OFF_TCTL : OFF_RCTL));
                op.mask = DATA_W'(3'h7) << RATE_LSB;
                op.val  = DATA_W'(m10 ? 3'd0 : 3'd2) << RATE_LSB;
            end
            11: begin
                op.kind = K_RMW;
                op.addr = ADDR_W'(PCS_BASE + int'(lane) * PCS_STRIDE);
                op.mask = DATA_W'(1) << BIT_PCS;
                op.val  = DATA_W'(!m10) << BIT_PCS;
            end
            12, 13, 14, 15, 16, 17: begin
                op.kind = K_WRITE;
                op.addr = ADDR_W'(base + eq_off(k));
                op.val  = eq_word(k, m10);
            end
            18, 19: if (powered) begin
                op.kind = K_RMW;
                op.addr = ADDR_W'(base + ((step == 18) ? OFF_TRST : OFF_RRST));
                op.mask = RREQ_M;
                op.val  = RREQ_M;
            end
            20, 21: if (powered) begin
                op.kind = K_POLL;
                op.addr = ADDR_W'(base + ((step == 20) ? OFF_TRST : OFF_RRST));
                op.mask = RDON_M;
                op.val  = RDON_M;
            end
            default: op.kind = K_SKIP;
        endcase
    end
endmodule

// File: rtl/lane_mode_seq.sv
// Top of the lane protocol switch sequencer: accepts a request, checks it,
// then walks the step list over the register port. Assumes read data is
// valid one cycle after the read strobe.
module lane_mode_seq
    import lms_pkg::*;
#(
    parameter int NUM_LANE = 8,
    parameter int NUM_PLL  = 2,
    localparam int LANE_W  = $clog2(NUM_LANE),
    localparam int PLL_W   = (NUM_PLL > 1) ? $clog2(NUM_PLL) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [LANE_W-1:0]    req_lane,
    input  logic                 req_mode_10g,
    input  logic [1:0]           req_cur_proto,
    input  logic                 req_powered,
    input  logic [NUM_PLL-1:0]   pll_disabled,
    input  logic [2*NUM_PLL-1:0] pll_class,
    output logic                 busy,
    output logic                 done,
    output logic                 err,
    output logic                 reg_rd_en,
    output logic                 reg_wr_en,
    output logic [ADDR_W-1:0]    reg_addr,
    output logic [DATA_W-1:0]    reg_wdata,
    input  logic [DATA_W-1:0]    reg_rdata
);
    seq_state_e          st;
    logic [STEP_W-1:0]   step;
    logic [LANE_W-1:0]   lane_q;
    logic                m10_q, old10_q, pwr_q;
    logic [PLL_W-1:0]    pll_q;
    logic                pll_found;
    logic [PLL_W-1:0]    pll_idx;
    logic                bad_req;
    step_t               op;

    lms_pll_pick #(.NUM_PLL(NUM_PLL)) u_pick (
        .dis      (pll_disabled),
        .cls      (pll_class),
        .want_10g (req_mode_10g),
        .found    (pll_found),
        .idx      (pll_idx)
    );

    lms_step_gen #(.NUM_LANE(NUM_LANE), .NUM_PLL(NUM_PLL)) u_steps (
        .step    (step),
        .lane    (lane_q),
        .m10     (m10_q),
        .old10   (old10_q),
        .pll     (pll_q),
        .powered (pwr_q),
        .op      (op)
    );

    // Refuse unknown present protocols and modes no PLL serves
    assign bad_req = !((req_cur_proto == PROTO_1G) || (req_cur_proto == PROTO_10G)) || !pll_found;

    // Sequencer state machine and registered register-port outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            step      <= '0;
            lane_q    <= '0;
            m10_q     <= 1'b0;
            old10_q   <= 1'b0;
            pwr_q     <= 1'b0;
            pll_q     <= '0;
            busy      <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
            reg_rd_en <= 1'b0;
            reg_wr_en <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
        end else begin
            done      <= 1'b0;
            err       <= 1'b0;
            reg_wr_en <= 1'b0;
            case (st)
                S_IDLE: if (req_valid) begin
                    if (bad_req) begin
                        err <= 1'b1;
                    end else begin
                        lane_q  <= req_lane;
                        m10_q   <= req_mode_10g;
                        old10_q <= (req_cur_proto == PROTO_10G);
                        pwr_q   <= req_powered;
                        pll_q   <= pll_idx;
                        step    <= '0;
                        busy    <= 1'b1;
                        st      <= S_RUN;
                    end
                end
                S_RUN: begin
                    if (step == STEP_W'(N_STEPS)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                        st   <= S_IDLE;
                    end else begin
                        case (op.kind)
                            K_SKIP: step <= step + 1'b1;
                            K_WRITE: begin
                                reg_wr_en <= 1'b1;
                                reg_addr  <= op.addr;
                                reg_wdata <= op.val;
                                step      <= step + 1'b1;
                            end
                            default: begin
                                reg_rd_en <= 1'b1;
                                reg_addr  <= op.addr;
                                st        <= S_RDWAIT;
                            end
                        endcase
                    end
                end
                S_RDWAIT: begin
                    reg_rd_en <= 1'b0;
                    st        <= S_RDCAP;
                end
                default: begin
                    if (op.kind == K_POLL) begin
                        if ((reg_rdata & op.mask) == op.val) step <= step + 1'b1;
                    end else begin
                        reg_wr_en <= 1'b1;
                        reg_wdata <= (reg_rdata & ~op.mask) | (op.val & op.mask);
                        step      <= step + 1'b1;
                    end
                    st <= S_RUN;
                end
            endcase
        end
    end
endmodule

// File: rtl/lms_checker.sv
// Protocol checks on the sequencer's handshake and register strobes.
// Assumes synchronous active-low reset; attached by bind below.
module lms_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic err,
    input logic reg_rd_en,
    input logic reg_wr_en
);
    // R10: a read strobe never coincides with a write strobe
    assert_rdwr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd_en && reg_wr_en));

    // R10: a read strobe lasts a single cycle
    assert_read_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> !reg_rd_en);

    // R2: no register traffic outside a sequence
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!reg_rd_en && !reg_wr_en));

    // R1: a refused request does not start a sequence
    assert_err_no_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);

    // R2: done marks the end of a sequence
    assert_done_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R2: a sequence starts only from a request
    assert_start_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
endmodule

bind lane_mode_seq lms_checker u_lms_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .reg_rd_en (reg_rd_en),
    .reg_wr_en (reg_wr_en)
);

// File: tb/tb_lane_mode_seq.sv
// Self-checking bench: register model with delayed poll answers, directed
// corners and seeded random requests checked against a bench-side model.
module tb_lane_mode_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_lane = '0;
    logic        req_mode_10g = 1'b0;
    logic [1:0]  req_cur_proto = '0;
    logic        req_powered = 1'b0;
    logic [1:0]  pll_disabled = '0;
    logic [3:0]  pll_class = '0;
    logic        busy, done, err, reg_rd_en, reg_wr_en;
    logic [15:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata = '0;

    int total = 0;
    int bad = 0;
    logic [31:0] mem [int unsigned];
    logic [31:0] exp_mem [int unsigned];
    int unsigned wlog [$];
    int unsigned exp_wl [$];
    int rst_cnt = 0;
    int acc_cnt = 0;

    lane_mode_seq dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int unsigned lb(input int l);
        return 'h800 + l * 'h100;
    endfunction

    function automatic bit is_rst(input int unsigned a);
        return (a >= 'h800) && (a < 'h1000) && (((a & 'hFF) == 'h20) || ((a & 'hFF) == 'h40));
    endfunction

    // Register model: reset words answer "still busy" for a few reads after a write
    always @(posedge clk) begin
        int unsigned a;
        logic [31:0] v;
        a = 32'(reg_addr);
        if (reg_rd_en) begin
            v = mem.exists(a) ? mem[a] : 32'h0;
            if (is_rst(a) && rst_cnt > 0) begin
                v[27] = 1'b1;
                v[30] = 1'b0;
                rst_cnt--;
            end
            reg_rdata <= v;
            acc_cnt++;
        end
        if (reg_wr_en) begin
            v = reg_wdata;
            if (is_rst(a)) begin
                if (v[31]) v[30] = 1'b1;
                v[27] = 1'b0;
                v[31] = 1'b0;
                rst_cnt = 3;
            end
            mem[a] = v;
            wlog.push_back(a);
            acc_cnt++;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic string tag_of(input int unsigned a);
        if (a == 'h10A0 || a == 'h10B0) return "R3";
        if (a >= 'h1800) return "R8";
        if ((a & 'hFF) == 'h00) return "R5";
        if ((a & 'hFF) == 'h24 || (a & 'hFF) == 'h44) return "R6";
        if (is_rst(a)) return "R11";
        return "R9";
    endfunction

    // Expected final register image and write order for an accepted request
    task automatic model(input int l, input bit m10, input bit old10, input int pll, input bit pwr);
        int unsigned b, sh, oa, na, tg, rg, pc;
        logic [31:0] eqv [6];
        int unsigned eqo [6];
        b = lb(l); sh = 4 * (7 - l); tg = b + 'h24; rg = b + 'h44; pc = 'h1804 + l * 'h10;
        eqo = '{'h30, 'h48, 'h50, 'h54, 'h58, 'h74};
        if (m10) eqv = '{32'h10808307, 32'h10000000, 32'h0, 32'h001F0000, 32'h81000020, 32'h00002000};
        else     eqv = '{32'h00808006, 32'h04310000, 32'h9F800000, 32'h001F0000, 32'h0, 32'h0};
        if (pwr) begin exp_wl.push_back(b + 'h20); exp_wl.push_back(b + 'h40); end
        oa = old10 ? 'h10B0 : 'h10A0;
        exp_mem[oa] = exp_mem[oa] & ~(32'hF << sh);
        exp_wl.push_back(oa);
        na = m10 ? 'h10B0 : 'h10A0;
        exp_mem[na] = (exp_mem[na] & ~(32'hF << sh)) | ((m10 ? 32'h9 : 32'h1) << sh);
        exp_wl.push_back(na);
        exp_mem[b] = (exp_mem[b] & ~32'hFF) | (m10 ? 32'h52 : 32'h08);
        exp_wl.push_back(b);
        exp_mem[tg][28] = pll[0]; exp_mem[rg][28] = pll[0];
        exp_wl.push_back(tg); exp_wl.push_back(rg);
        exp_mem[tg][26:24] = m10 ? 3'd0 : 3'd2; exp_mem[rg][26:24] = m10 ? 3'd0 : 3'd2;
        exp_wl.push_back(tg); exp_wl.push_back(rg);
        exp_mem[pc][11] = !m10;
        exp_wl.push_back(pc);
        for (int i = 0; i < 6; i++) begin
            exp_mem[b + eqo[i]] = eqv[i];
            exp_wl.push_back(b + eqo[i]);
        end
        if (pwr) begin
            for (int i = 0; i < 2; i++) begin
                int unsigned r;
                r = b + (i == 0 ? 'h20 : 'h40);
                exp_mem[r][27] = 1'b0; exp_mem[r][31] = 1'b0; exp_mem[r][30] = 1'b1;
                exp_wl.push_back(r);
            end
        end
    endtask

    task automatic run_req(input int l, input bit m10, input logic [1:0] cur, input bit pwr,
                           input logic [1:0] dis, input logic [3:0] cls, input bit intrude);
        int pll;
        bit rej;
        int cnt;
        pll = -1;
        for (int i = 1; i >= 0; i--)
            if (!dis[i] && cls[2*i +: 2] == (m10 ? 2'd2 : 2'd1)) pll = i;
        rej = !(cur == 2'd1 || cur == 2'd2) || (pll < 0);
        exp_mem = mem;
        exp_wl.delete();
        if (!rej) model(l, m10, cur == 2'd2, pll, pwr);
        @(negedge clk);
        wlog.delete();
        acc_cnt = 0;
        req_lane = 3'(l); req_mode_10g = m10; req_cur_proto = cur; req_powered = pwr;
        pll_disabled = dis; pll_class = cls; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (rej) begin
            check(err == 1'b1 && busy == 1'b0, "R1 err pulse", {30'd0, err, busy}, 32'h2);
            repeat (3) @(negedge clk);
            check(acc_cnt == 0, "R1 no access", 32'(acc_cnt), 32'h0);
        end else begin
            check(busy == 1'b1 && err == 1'b0, "R2 busy rise", {30'd0, busy, err}, 32'h2);
            if (intrude) begin
                req_lane = 3'((l + 1) % NL); req_mode_10g = !m10; req_cur_proto = 2'd1;
                req_powered = 1'b1; pll_disabled = 2'b00; pll_class = 4'b1001; req_valid = 1'b1;
                @(negedge clk);
                req_valid = 1'b0;
            end
            cnt = 0;
            while (!done && cnt < 3000) begin @(negedge clk); cnt++; end
            check(done == 1'b1 && busy == 1'b0, "R2 done", {30'd0, done, busy}, 32'h2);
            @(negedge clk);
            check(busy == 1'b0, "R2 idle after", 32'(busy), 32'h0);
        end
        check(wlog.size() == exp_wl.size(), "R12 write count", 32'(wlog.size()), 32'(exp_wl.size()));
        for (int i = 0; i < wlog.size() && i < exp_wl.size(); i++)
            check(wlog[i] == exp_wl[i], "R12 write order", wlog[i], exp_wl[i]);
        foreach (exp_mem[k]) begin
            logic [31:0] got;
            got = mem.exists(k) ? mem[k] : 32'h0;
            check(got === exp_mem[k], {tag_of(k), " R4 R7 R10 register"}, got, exp_mem[k]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int l = 0; l < NL; l++) begin
            int unsigned offs [11];
            offs = '{'h00, 'h20, 'h24, 'h30, 'h40, 'h44, 'h48, 'h50, 'h54, 'h58, 'h74};
            for (int j = 0; j < 11; j++) begin
                logic [31:0] v;
                v = $urandom;
                if (offs[j] == 'h20 || offs[j] == 'h40) begin v[27] = 0; v[30] = 0; v[31] = 0; end
                mem[lb(l) + offs[j]] = v;
            end
            mem['h1804 + l * 'h10] = $urandom;
        end
        mem['h10A0] = $urandom;
        mem['h10B0] = $urandom;
        repeat (3) @(negedge clk);
        check({busy, done, err, reg_rd_en, reg_wr_en} == 5'b0, "R2 reset state",
              {27'd0, busy, done, err, reg_rd_en, reg_wr_en}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 lane 0 top nibble, 1G to 10G, powered (R11), first PLL
        run_req(0, 1'b1, 2'd1, 1'b1, 2'b00, 4'b1010, 1'b0);
        // R3 lane 7 bottom nibble, 10G to 1G, unpowered, second PLL (R6)
        run_req(7, 1'b0, 2'd2, 1'b0, 2'b00, 4'b0110, 1'b0);
        // R6 first PLL disabled, second chosen
        run_req(3, 1'b0, 2'd1, 1'b1, 2'b01, 4'b0101, 1'b0);
        // R1 unknown present protocol
        run_req(2, 1'b1, 2'd0, 1'b1, 2'b00, 4'b1010, 1'b0);
        // R1 no PLL of the right class
        run_req(4, 1'b1, 2'd1, 1'b0, 2'b10, 4'b1001, 1'b0);
        // R2 request during busy has no effect
        run_req(5, 1'b1, 2'd2, 1'b1, 2'b00, 4'b0010, 1'b1);
        for (int n = 0; n < 40; n++) begin
            logic [1:0] cur;
            cur = (($urandom % 8) == 0) ? 2'(($urandom % 2) * 3) : 2'(1 + ($urandom % 2));
            run_req(int'($urandom % NL), 1'($urandom), cur, 1'($urandom),
                    2'($urandom), 4'($urandom), 1'(($urandom % 5) == 0));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule